// File: doc/BRIEF.md
# Binary to Decimal ASCII Converter

This block turns an unsigned binary integer into a decimal character string. It stores the string in a fixed buffer of twelve bytes, and the string ends with a zero byte. A caller pulses `start` with the value on `value_i`. The block then splits the value into decimal digits by dividing it by ten over and over. Each remainder becomes the next character, and each quotient becomes the next value to divide.

Digits come out least significant first, so the block fills the buffer from the back towards the front. The first character goes just ahead of the terminator. The loop runs at least once, so an input of zero gives the single character `0`. When the last quotient reaches zero, the block raises `done` for one cycle. At that point `first_idx_o` holds the position of the leading character. The caller reads the string from that position up to the terminator.

The divide-by-ten is built into the block as a restoring divider that handles one bit per cycle. Each digit costs a fixed number of cycles.

Top module: `dec_ascii_conv`

## Requirements
- R1: After reset, `done` is 0, every byte of `text_o` is 0x00, and `first_idx_o` is 11.
- R2: After a conversion, the bytes from `first_idx_o` through index 10 spell the decimal value of the input, most significant digit first. Each character is 0x30 plus the digit. Byte i occupies `text_o[8*i+7:8*i]`.
- R3: Byte index 11 of `text_o` is always 0x00, the terminator.
- R4: An input of 0 gives the character 0x30 at index 10 and sets `first_idx_o` to 10.
- R5: `first_idx_o` equals 11 minus the number of digits, and every byte below `first_idx_o` is 0x00.
- R6: `done` is high for exactly one cycle. For a result of D digits, it is high in the cycle that follows the clock edge D*(DATA_W+1) edges after the edge that accepted `start`. That is 33 edges per digit for a 32-bit input.
- R7: A `start` that arrives while a conversion is running is ignored. A `start` in the `done` cycle or later, while idle, is accepted.
- R8: `text_o` and `first_idx_o` keep the last result until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion of `value_i` (taken only when idle) |
| value_i | input | 32 | Unsigned value to convert |
| done | output | 1 | One-cycle pulse when the string is complete |
| text_o | output | 96 | Twelve-byte string buffer, byte i at bits 8*i+7..8*i |
| first_idx_o | output | 4 | Index of the leading character |

## Verification
The bench targets the inputs where the digit count changes (9, 10) and zero, since zero still needs one pass through the loop. It also covers the 32-bit maximum, which fills ten positions. A design that tested the quotient before its first digit would leave an empty string for zero. A design with an off-by-one in the write pointer would misplace the leading digit or overwrite the terminator. The bench compares `done` every clock against a model that counts 33 cycles per digit, so a wrong per-digit cost or a stretched pulse shows up at once. It also pulses `start` in the middle of a conversion to catch a design that restarts instead of ignoring the request.

// File: rtl/dac_pkg.sv
// Shared definitions for the decimal ASCII converter.
// Assumes: base-ten output, characters encoded as 0x30 plus the digit.
package dac_pkg;
    localparam int unsigned RADIX      = 10;
    localparam int unsigned REM_W      = 4;
    localparam logic [3:0]  ASCII_HIGH = 4'h3;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } conv_state_t;
endpackage

// File: rtl/div10_unit.sv
// Restoring divider by ten, one quotient bit per cycle.
// A pulse on go_i loads the dividend. After DATA_W step cycles, res_valid_o
// rises and stays high until the next go_i, or until ack_i with no new go_i.
// Assumes: the remainder always fits in REM_W bits.
module div10_unit
    import dac_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic              ack_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] quot_o,
    output logic [REM_W-1:0]  rem_o
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] quot_q;
    logic [REM_W-1:0]  rem_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_q;
    logic [REM_W:0]    trial;
    logic              fits;
    logic [DATA_W-1:0] dvd_q;

    // Bring the next dividend bit into the trial remainder and compare it against the radix.
    always_comb begin
        trial = {rem_q, quot_q[DATA_W-1]};
        fits  = (trial >= (REM_W+1)'(RADIX));
    end

    // Load on go_i, then run one restoring step per cycle until the count is exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
        end else if (go_i) begin
            quot_q <= dividend_i;
            rem_q  <= '0;
            cnt_q  <= CNT_W'(DATA_W);
            run_q  <= 1'b1;
        end else if (cnt_q != '0) begin
            quot_q <= {quot_q[DATA_W-2:0], fits};
            rem_q  <= fits ? REM_W'(trial - (REM_W+1)'(RADIX)) : trial[REM_W-1:0];
            cnt_q  <= cnt_q - 1'b1;
        end else if (ack_i) begin
            run_q  <= 1'b0;
        end
    end

    // Keep a copy of the dividend so the result can be checked against it.
    always_ff @(posedge clk) begin
        if (!rst_n)    dvd_q <= '0;
        else if (go_i) dvd_q <= dividend_i;
    end

    assign res_valid_o = run_q && (cnt_q == '0);
    assign quot_o      = quot_q;
    assign rem_o       = rem_q;

    // R2: a finished result satisfies quotient*10 + remainder == dividend, with remainder below ten.
    a_r2_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (({4'b0, quot_q} * (DATA_W+4)'(RADIX)) + (DATA_W+4)'(rem_q) == {4'b0, dvd_q})
                        && (rem_q < REM_W'(RADIX)));
endmodule

// File: rtl/char_buffer.sv
// String store of BUF_LEN bytes. The last byte is a constant terminator of zero.
// clr_i zeroes every byte. wr_i writes one character at wr_idx_i.
// Assumes: wr_idx_i never addresses the terminator.
module char_buffer #(
    parameter int unsigned BUF_LEN = 12,
    parameter int unsigned IDX_W   = $clog2(BUF_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               wr_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [7:0]         wr_char_i,
    output logic [8*BUF_LEN-1:0] text_o
);
    genvar gi;
    generate
        for (gi = 0; gi < BUF_LEN - 1; gi++) begin : g_byte
            logic [7:0] byte_q;
            // Clear on reset or on a new conversion; take the character when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n || clr_i)
                    byte_q <= 8'h00;
                else if (wr_i && (wr_idx_i == IDX_W'(gi)))
                    byte_q <= wr_char_i;
            end
            assign text_o[8*gi +: 8] = byte_q;
        end
    endgenerate

    assign text_o[8*(BUF_LEN-1) +: 8] = 8'h00;

    // R3: a write never lands on the terminator slot.
    a_r3_no_term_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (wr_idx_i < IDX_W'(BUF_LEN - 1)));
endmodule

// File: rtl/dec_ascii_conv.sv
// Top level: sequences divide-by-ten steps and writes each remainder as a character,
// filling the buffer from the position just ahead of the terminator towards index 0.
// Assumes: BUF_LEN - 1 is at least the decimal digit count of the largest DATA_W value.
module dec_ascii_conv
    import dac_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned BUF_LEN = 12,
    localparam int unsigned IDX_W  = $clog2(BUF_LEN),
    localparam int unsigned TXT_W  = 8 * BUF_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] value_i,
    output logic              done,
    output logic [TXT_W-1:0]  text_o,
    output logic [IDX_W-1:0]  first_idx_o
);
    localparam logic [IDX_W-1:0] TERM_IDX = IDX_W'(BUF_LEN - 1);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(BUF_LEN - 2);

    conv_state_t       state_q;
    logic [IDX_W-1:0]  widx_q;
    logic [IDX_W-1:0]  first_q;
    logic              done_q;

    logic              accept;
    logic              res_valid;
    logic [DATA_W-1:0] quot;
    logic [REM_W-1:0]  rem;
    logic              last_digit;
    logic              div_go;
    logic [DATA_W-1:0] div_in;
    logic              wr_en;
    logic [7:0]        wr_char;

    // Decide this cycle's actions: accept a request, write a digit, relaunch the divider.
    always_comb begin
        accept     = (state_q == ST_IDLE) && start;
        wr_en      = (state_q == ST_RUN) && res_valid;
        last_digit = (quot == '0);
        div_go     = accept || (wr_en && !last_digit);
        div_in     = accept ? value_i : quot;
        wr_char    = {ASCII_HIGH, rem};
    end

    div10_unit #(.DATA_W(DATA_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (div_go),
        .dividend_i  (div_in),
        .ack_i       (wr_en),
        .res_valid_o (res_valid),
        .quot_o      (quot),
        .rem_o       (rem)
    );

    char_buffer #(.BUF_LEN(BUF_LEN), .IDX_W(IDX_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (accept),
        .wr_i      (wr_en),
        .wr_idx_i  (widx_q),
        .wr_char_i (wr_char),
        .text_o    (text_o)
    );

    // Control sequence: idle, run through the digits, pulse done after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            widx_q  <= LAST_POS;
            first_q <= TERM_IDX;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q <= ST_RUN;
                widx_q  <= LAST_POS;
                first_q <= TERM_IDX;
            end else if (wr_en) begin
                first_q <= widx_q;
                widx_q  <= widx_q - 1'b1;
                if (last_digit) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign done        = done_q;
    assign first_idx_o = first_q;

    // R6: done never lasts more than one cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: every character written is a decimal digit.
    a_r2_char_digit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_char >= 8'h30) && (wr_char <= 8'h39));

    // R5: at completion the leading position holds a digit and the byte before it is empty.
    a_r5_lead_char: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (text_o[8*first_idx_o +: 8] != 8'h00) && (first_idx_o < TERM_IDX)
                 && ((first_idx_o == '0) || (text_o[8*(first_idx_o - 1'b1) +: 8] == 8'h00)));

    // R7: a request during a conversion does not restart or reset the write position.
    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start && !wr_en) |=> (state_q == ST_RUN) && $stable(widx_q));

    // R3: the terminator byte stays zero.
    a_r3_terminator: assert property (@(posedge clk) disable iff (!rst_n)
        text_o[8*(BUF_LEN-1) +: 8] == 8'h00);
endmodule

// File: tb/sim_dec_ascii_conv.sv
// Bench: behavioural per-clock model of latency and result, compared each cycle.
module sim_dec_ascii_conv;
    localparam int W   = 32;
    localparam int LAT = W + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] value_i = '0;
    logic        done;
    logic [95:0] text_o;
    logic [3:0]  first_idx_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R2";

    dec_ascii_conv u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .value_i(value_i),
        .done(done), .text_o(text_o), .first_idx_o(first_idx_o)
    );

    always #2 clk = ~clk;

    // Reference formatter: decimal digits written backwards from index 10.
    function automatic logic [95:0] fmt_text(input logic [31:0] v);
        logic [95:0] t = '0;
        longint unsigned x = v;
        int idx = 11;
        do begin
            idx--;
            t[idx*8 +: 8] = 8'(8'h30 + (x % 10));
            x = x / 10;
        end while (x != 0);
        return t;
    endfunction

    function automatic int ndig(input logic [31:0] v);
        longint unsigned x = v;
        int n = 0;
        do begin n++; x = x / 10; end while (x != 0);
        return n;
    endfunction

    // Model state
    logic        m_busy = 1'b0;
    int          m_cnt = 0;
    logic [31:0] m_val = '0;
    logic        m_done = 1'b0;
    logic [95:0] m_text = '0;
    logic [3:0]  m_idx = 4'd11;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_cnt <= 0; m_done <= 1'b0;
            m_text <= '0; m_idx <= 4'd11;
        end else begin
            m_done <= 1'b0;
            if (!m_busy && start) begin
                m_busy <= 1'b1;
                m_cnt  <= ndig(value_i) * LAT;
                m_val  <= value_i;
            end else if (m_busy) begin
                if (m_cnt == 1) begin
                    m_busy <= 1'b0;
                    m_done <= 1'b1;
                    m_text <= fmt_text(m_val);
                    m_idx  <= 4'(11 - ndig(m_val));
                end
                m_cnt <= m_cnt - 1;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            checks++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL R6 done actual=%0b expected=%0b", done, m_done);
            end
            if (!m_busy) begin
                checks++;
                if (text_o !== m_text || first_idx_o !== m_idx) begin
                    errors++;
                    $display("FAIL %s/R5/R8 text actual=%h idx=%0d expected=%h idx=%0d",
                             tag, text_o, first_idx_o, m_text, m_idx);
                end
                checks++;
                if (text_o[95:88] !== 8'h00) begin
                    errors++;
                    $display("FAIL R3 terminator actual=%h expected=00", text_o[95:88]);
                end
            end
        end
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected<200000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic convert(input logic [31:0] v);
        @(negedge clk);
        start = 1'b1; value_i = v;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
    endtask

    task automatic expect_idle(input logic [31:0] v, input string r);
        checks++;
        if (text_o !== fmt_text(v) || first_idx_o !== 4'(11 - ndig(v))) begin
            errors++;
            $display("FAIL %s value=%0d actual=%h idx=%0d expected=%h idx=%0d",
                     r, v, text_o, first_idx_o, fmt_text(v), 11 - ndig(v));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (done !== 1'b0 || text_o !== '0 || first_idx_o !== 4'd11) begin
            errors++;
            $display("FAIL R1 reset actual=%b/%h/%0d expected=0/0/11", done, text_o, first_idx_o);
        end
        rst_n = 1'b1;

        tag = "R4";
        convert(32'd0);
        expect_idle(32'd0, "R4");
        checks++;
        if (text_o[87:80] !== 8'h30 || first_idx_o !== 4'd10) begin
            errors++;
            $display("FAIL R4 zero actual=%h idx=%0d expected=30 idx=10", text_o[87:80], first_idx_o);
        end

        tag = "R2";
        convert(32'd9);          expect_idle(32'd9, "R2");
        convert(32'd10);         expect_idle(32'd10, "R5");
        convert(32'd2037);       expect_idle(32'd2037, "R2");
        convert(32'hFFFF_FFFF);  expect_idle(32'hFFFF_FFFF, "R5");

        // R8: result holds while idle with inputs moving.
        tag = "R8";
        value_i = 32'd123;
        repeat (20) @(negedge clk);
        expect_idle(32'hFFFF_FFFF, "R8");

        // R7: start mid-conversion is ignored.
        tag = "R7";
        @(negedge clk);
        start = 1'b1; value_i = 32'd4567;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        start = 1'b1; value_i = 32'd88;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        expect_idle(32'd4567, "R7");

        // R7: start in the done cycle is accepted.
        @(negedge clk);
        start = 1'b1; value_i = 32'd31;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b1; value_i = 32'd506;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        expect_idle(32'd506, "R7");

        tag = "R2";
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom >> ($urandom % 32);
            convert(r);
            expect_idle(r, "R2");
        end

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule